// File: doc/BRIEF.md
# Endian-Aware Sub-Word Bus Steering Unit

This unit connects a load/store pipeline to a 32-bit system bus that moves only whole aligned words. It takes one access per request: byte, halfword, word or doubleword, plus a sign-extension choice and a big-endian mode bit. It forms the effective address as base plus a sign-extended 16-bit offset. It then runs one or two bus transfers over a request/ready handshake.

For loads, the unit picks the addressed lane out of the returned word. It sign- or zero-extends that lane to 64 bits and presents the result for one cycle. For byte and halfword stores, it reads the whole word, replaces only the target lane and writes the word back. A doubleword moves as two word transfers: the upper half goes at the base address and the lower half at base plus four.

A request is taken only while the unit is idle. The caller watches `busy` and the completion strobes. Size codes the unit does not support finish at once with an error strobe and no bus activity.

Top module: `subword_bus_steer`

## Requirements
- R1: The effective address equals `req_base` plus `req_offset` sign-extended to the address width.
- R2: Byte (size code 0) and halfword (size code 1) accesses put the effective address with bits 1:0 forced to zero on `bus_addr`.
- R3: The byte lane index is effective address bits 1:0 in little-endian mode (`big_endian`=0) and those bits XOR 3 in big-endian mode. The byte is taken from or placed at bit position lane index times 8.
- R4: The halfword lane offset is effective address bits 1:0 in little-endian mode and those bits XOR 2 in big-endian mode. In big-endian mode, offset 0 therefore selects bits 31:16.
- R5: A byte or halfword store first performs a read (`bus_we`=0) of the aligned word. It then writes that word back with only the target lane replaced. A word store (size code 2) performs a single write with no read.
- R6: A doubleword (size code 3) load or store performs two transfers. Bits 63:32 go at the effective address and bits 31:0 at the effective address plus 4, in that order.
- R7: With `req_signed`=1, byte, halfword and word loads are sign-extended to 64 bits. With `req_signed`=0 they are zero-extended. Doubleword loads return the 64 bits unchanged.
- R8: `busy` is high from the cycle after acceptance until the last transfer completes. While `bus_req` is high and `bus_ready` low, the bus address, write enable and write data stay unchanged.
- R9: A load raises `ld_valid` for exactly one cycle, in the cycle `busy` falls, with `ld_data` holding the result. A store never raises `ld_valid`.
- R10: A size code of 4 to 7 is accepted without any bus transfer. `err` is high for one cycle in the next cycle, and `busy` stays low.
- R11: `req_valid` asserted while `busy` is high is ignored and causes no bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 3 | 0 byte, 1 halfword, 2 word, 3 doubleword, 4-7 invalid |
| req_signed | input | 1 | Sign-extend load data |
| big_endian | input | 1 | Byte-order mode |
| req_base | input | ADDR_W | Base register value |
| req_offset | input | OFF_W | Signed address offset |
| req_wdata | input | 2*BUS_W | Store data, right-aligned |
| busy | output | 1 | Access in progress |
| ld_valid | output | 1 | Load result strobe |
| ld_data | output | 2*BUS_W | Extended load result |
| err | output | 1 | Invalid-size strobe |
| bus_req | output | 1 | Bus transfer request |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | ADDR_W | Bus word address |
| bus_wdata | output | BUS_W | Bus write data |
| bus_rdata | input | BUS_W | Bus read data |
| bus_ready | input | 1 | Transfer completes this cycle |

## Verification
The assertions check the handshake rules on every cycle: request signals held stable while the bus stalls, a request only while busy, a one-cycle load strobe while idle, and alignment plus read-first on sub-word accesses. They also check that invalid sizes produce an error strobe with no bus request. Lane selection under both byte orders, the merged word left in memory after a read-modify-write, extension of each size and the upper-then-lower order of doubleword transfers can only be shown by the bench's scenarios. Those scenarios compare memory contents and load results against precomputed values.

// File: rtl/bsteer_pkg.sv
package bsteer_pkg;
  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3
  } size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,      // single read (load or first step of read-modify-write)
    ST_RD_HI,   // doubleword load, upper word
    ST_RD_LO,   // doubleword load, lower word
    ST_WR_HI,   // doubleword store, upper word
    ST_WR       // final write of any store
  } state_e;
endpackage

// File: rtl/bsteer_lane.sv
// Lane selection, extraction and merge for byte/halfword accesses.
module bsteer_lane #(
  parameter int BUS_W = 32
) (
  input  logic [$clog2(BUS_W/8)-1:0] off,
  input  logic                       be,
  input  logic                       half,
  input  logic [BUS_W-1:0]           rdata,
  input  logic [15:0]                wsub,
  output logic [15:0]                ext,
  output logic [BUS_W-1:0]           merged
);
  localparam int LANE_W = $clog2(BUS_W/8);
  localparam int SH_W   = LANE_W + 3;

  logic [LANE_W-1:0] flip;
  logic [LANE_W-1:0] lane;
  logic [SH_W-1:0]   shift;
  logic [BUS_W-1:0]  fmask;
  logic [BUS_W-1:0]  lmask;
  logic [BUS_W-1:0]  shifted;

  always_comb begin
    // big-endian flips all lane bits for bytes, all but bit 0 for halfwords
    flip    = {LANE_W{be}} & ~{{(LANE_W-1){1'b0}}, half};
    lane    = off ^ flip;
    shift   = {lane, 3'b000};
    fmask   = half ? BUS_W'(16'hFFFF) : BUS_W'(16'h00FF);
    lmask   = fmask << shift;
    shifted = rdata >> shift;
    ext     = shifted[15:0] & fmask[15:0];
    merged  = (rdata & ~lmask) | ((BUS_W'(wsub) << shift) & lmask);
  end
endmodule

// File: rtl/bsteer_extend.sv
// Sign or zero extension of load data to the full result width.
module bsteer_extend
  import bsteer_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic [2:0]         size,
  input  logic               sgn,
  input  logic [BUS_W-1:0]   raw,
  output logic [2*BUS_W-1:0] res
);
  localparam int RES_W = 2 * BUS_W;

  always_comb begin
    if (size == SZ_BYTE)
      res = {{(RES_W-8){sgn & raw[7]}}, raw[7:0]};
    else if (size == SZ_HALF)
      res = {{(RES_W-16){sgn & raw[15]}}, raw[15:0]};
    else
      res = {{BUS_W{sgn & raw[BUS_W-1]}}, raw};
  end
endmodule

// File: rtl/subword_bus_steer.sv
module subword_bus_steer
  import bsteer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int BUS_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [2:0]           req_size,
  input  logic                 req_signed,
  input  logic                 big_endian,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [OFF_W-1:0]     req_offset,
  input  logic [2*BUS_W-1:0]   req_wdata,
  output logic                 busy,
  output logic                 ld_valid,
  output logic [2*BUS_W-1:0]   ld_data,
  output logic                 err,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [BUS_W-1:0]     bus_wdata,
  input  logic [BUS_W-1:0]     bus_rdata,
  input  logic                 bus_ready
);
  localparam int DATA_W = 2 * BUS_W;
  localparam int LANE_W = $clog2(BUS_W/8);
  localparam int STEP   = BUS_W / 8;

  state_e             state;
  logic [2:0]         size_q;
  logic               sgn_q, be_q, store_q;
  logic [LANE_W-1:0]  off_q;
  logic [DATA_W-1:0]  wd_q;
  logic [BUS_W-1:0]   hi_q;

  logic [ADDR_W-1:0]  ea;
  logic [ADDR_W-1:0]  ea_aligned;
  logic               xfer;
  logic [15:0]        lane_ext;
  logic [BUS_W-1:0]   lane_merged;
  logic [BUS_W-1:0]   ext_raw;
  logic [DATA_W-1:0]  ext_res;

  assign ea         = req_base + {{(ADDR_W-OFF_W){req_offset[OFF_W-1]}}, req_offset};
  assign ea_aligned = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign xfer       = bus_req & bus_ready;
  assign busy       = (state != ST_IDLE);
  assign ext_raw    = (size_q == SZ_WORD) ? bus_rdata : {{(BUS_W-16){1'b0}}, lane_ext};

  bsteer_lane #(.BUS_W(BUS_W)) u_lane (
    .off    (off_q),
    .be     (be_q),
    .half   (size_q == SZ_HALF),
    .rdata  (bus_rdata),
    .wsub   (wd_q[15:0]),
    .ext    (lane_ext),
    .merged (lane_merged)
  );

  bsteer_extend #(.BUS_W(BUS_W)) u_ext (
    .size (size_q),
    .sgn  (sgn_q),
    .raw  (ext_raw),
    .res  (ext_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      size_q    <= '0;
      sgn_q     <= 1'b0;
      be_q      <= 1'b0;
      store_q   <= 1'b0;
      off_q     <= '0;
      wd_q      <= '0;
      hi_q      <= '0;
      ld_valid  <= 1'b0;
      ld_data   <= '0;
      err       <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      ld_valid <= 1'b0;
      err      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            size_q  <= req_size;
            sgn_q   <= req_signed;
            be_q    <= big_endian;
            store_q <= req_store;
            off_q   <= ea[LANE_W-1:0];
            wd_q    <= req_wdata;
            case (req_size)
              SZ_BYTE, SZ_HALF: begin
                bus_addr <= ea_aligned;
                bus_req  <= 1'b1;
                bus_we   <= 1'b0;
                state    <= ST_RD;
              end
              SZ_WORD: begin
                bus_addr  <= ea;
                bus_req   <= 1'b1;
                bus_we    <= req_store;
                bus_wdata <= req_wdata[BUS_W-1:0];
                state     <= req_store ? ST_WR : ST_RD;
              end
              SZ_DWORD: begin
                bus_addr  <= ea;
                bus_req   <= 1'b1;
                bus_we    <= req_store;
                bus_wdata <= req_wdata[DATA_W-1:BUS_W];
                state     <= req_store ? ST_WR_HI : ST_RD_HI;
              end
              default: err <= 1'b1;
            endcase
          end
        end
        ST_RD: if (xfer) begin
          if (store_q) begin
            bus_we    <= 1'b1;
            bus_wdata <= lane_merged;
            state     <= ST_WR;
          end else begin
            ld_data  <= ext_res;
            ld_valid <= 1'b1;
            bus_req  <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_RD_HI: if (xfer) begin
          hi_q     <= bus_rdata;
          bus_addr <= bus_addr + ADDR_W'(STEP);
          state    <= ST_RD_LO;
        end
        ST_RD_LO: if (xfer) begin
          ld_data  <= {hi_q, bus_rdata};
          ld_valid <= 1'b1;
          bus_req  <= 1'b0;
          state    <= ST_IDLE;
        end
        ST_WR_HI: if (xfer) begin
          bus_addr  <= bus_addr + ADDR_W'(STEP);
          bus_wdata <= wd_q[BUS_W-1:0];
          state     <= ST_WR;
        end
        ST_WR: if (xfer) begin
          bus_req <= 1'b0;
          bus_we  <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsteer_chk.sv
module bsteer_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_size,
  input logic              busy,
  input logic              ld_valid,
  input logic              err,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_ready
);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  p_req_busy_r8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  p_ldv_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    ld_valid |=> !ld_valid);

  p_ldv_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> !busy && !bus_req);

  p_bad_size_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy && (req_size > 3'd3) |=> err && !busy && !bus_req);

  // R2 alignment and R5 read-before-write for sub-word accesses
  p_sub_align_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !busy && (req_size < 3'd2) |=> bus_req && !bus_we && (bus_addr[1:0] == 2'b00));
endmodule

bind subword_bus_steer bsteer_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_size(req_size),
  .busy(busy), .ld_valid(ld_valid), .err(err), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready)
);

// File: tb/test_subword_bus_steer.sv
module test_subword_bus_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_signed = 1'b0, big_endian = 1'b0;
  logic [2:0]  req_size = 3'd0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [63:0] req_wdata = '0;
  logic        busy, ld_valid, err, bus_req, bus_we, bus_ready;
  logic [63:0] ld_data;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  subword_bus_steer i_subword_bus_steer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .big_endian(big_endian),
    .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
    .busy(busy), .ld_valid(ld_valid), .ld_data(ld_data), .err(err),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // bus model: word memory with programmable wait states and transfer log
  logic [31:0] mem [16];
  logic [1:0]  wcnt;
  logic [1:0]  ws = 2'd0;
  logic        pl_en = 1'b0, log_clr = 1'b0;
  logic [3:0]  pl_idx = '0;
  logic [31:0] pl_val = '0;
  logic [31:0] xa [4];
  logic        xw [4];
  int          xn;

  assign bus_ready = bus_req && (wcnt == ws);
  assign bus_rdata = mem[bus_addr[5:2]];

  always_ff @(posedge clk) begin
    if (rst || !bus_req || bus_ready) wcnt <= '0;
    else wcnt <= wcnt + 2'd1;
  end

  always @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_val;
    if (log_clr) xn <= 0;
    else if (bus_req && bus_ready) begin
      if (bus_we) mem[bus_addr[5:2]] <= bus_wdata;
      if (xn < 4) begin xa[xn] <= bus_addr; xw[xn] <= bus_we; end
      xn <= xn + 1;
    end
  end

  int checks = 0, errors = 0, cyc = 0;
  logic [63:0] got_data;
  logic        got_ldv, got_err;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    pl_en = 1'b1; pl_idx = idx; pl_val = val;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic acc(input bit st, input logic [2:0] sz, input bit sg, input bit be,
                     input logic [31:0] base, input logic [15:0] off, input logic [63:0] wd);
    int n;
    @(negedge clk);
    log_clr = 1'b1; req_valid = 1'b1; req_store = st; req_size = sz;
    req_signed = sg; big_endian = be; req_base = base; req_offset = off; req_wdata = wd;
    @(negedge clk);
    log_clr = 1'b0; req_valid = 1'b0;
    n = 0;
    while (busy && n < 1000) begin @(negedge clk); n++; end
    got_ldv = ld_valid; got_err = err; got_data = ld_data;
  endtask

  typedef struct packed {
    logic [2:0]  sz;
    logic        sg;
    logic        be;
    logic [31:0] base;
    logic [15:0] off;
    logic [63:0] exp;
  } vec_t;

  // memory word 0x10 = F1E2D3C4, 0x14 = 01234567
  localparam vec_t VT [12] = '{
    '{3'd0, 1'b1, 1'b0, 32'h10, 16'h0000, 64'hFFFF_FFFF_FFFF_FFC4}, // R3 R7 LE lane0
    '{3'd0, 1'b0, 1'b1, 32'h10, 16'h0000, 64'h0000_0000_0000_00F1}, // R3 BE lane3
    '{3'd0, 1'b1, 1'b1, 32'h20, 16'hFFF3, 64'hFFFF_FFFF_FFFF_FFC4}, // R1 negative offset
    '{3'd0, 1'b0, 1'b0, 32'h10, 16'h0002, 64'h0000_0000_0000_00E2}, // R3 LE lane2
    '{3'd1, 1'b1, 1'b0, 32'h10, 16'h0000, 64'hFFFF_FFFF_FFFF_D3C4}, // R4 R7
    '{3'd1, 1'b0, 1'b1, 32'h10, 16'h0000, 64'h0000_0000_0000_F1E2}, // R4 BE off0 upper
    '{3'd1, 1'b0, 1'b0, 32'h10, 16'h0002, 64'h0000_0000_0000_F1E2}, // R4 LE off2
    '{3'd1, 1'b1, 1'b1, 32'h10, 16'h0002, 64'hFFFF_FFFF_FFFF_D3C4}, // R4 BE off2 lower
    '{3'd2, 1'b1, 1'b0, 32'h10, 16'h0000, 64'hFFFF_FFFF_F1E2_D3C4}, // R7 word signed
    '{3'd2, 1'b0, 1'b1, 32'h10, 16'h0000, 64'h0000_0000_F1E2_D3C4}, // R7 word unsigned
    '{3'd3, 1'b1, 1'b0, 32'h10, 16'h0000, 64'hF1E2_D3C4_0123_4567}, // R6 dword
    '{3'd0, 1'b1, 1'b0, 32'h14, 16'h0001, 64'h0000_0000_0000_0045}  // R7 positive byte
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset busy", {63'd0, busy}, 64'd0);
    chk("R8 reset bus_req", {63'd0, bus_req}, 64'd0);
    chk("R9 reset ld_valid", {63'd0, ld_valid}, 64'd0);
    chk("R10 reset err", {63'd0, err}, 64'd0);
    rst = 1'b0;

    preload(4'd4, 32'hF1E2D3C4);
    preload(4'd5, 32'h01234567);

    for (int i = 0; i < 12; i++) begin
      ws = (i % 3 == 0) ? 2'd2 : 2'd0;
      acc(1'b0, VT[i].sz, VT[i].sg, VT[i].be, VT[i].base, VT[i].off, 64'd0);
      chk($sformatf("R7 vector %0d data", i), got_data, VT[i].exp);
      chk($sformatf("R9 vector %0d ld_valid", i), {63'd0, got_ldv}, 64'd1);
      if (VT[i].sz < 3'd2)
        chk($sformatf("R2 vector %0d aligned addr", i), {32'd0, xa[0]}, {32'd0, (VT[i].base + {{16{VT[i].off[15]}}, VT[i].off}) & 32'hFFFF_FFFC});
    end

    // R5 byte store big-endian: lane 3
    ws = 2'd0;
    preload(4'd6, 32'h11223344);
    acc(1'b1, 3'd0, 1'b0, 1'b1, 32'h18, 16'h0, 64'h0000_0000_0000_00AB);
    chk("R5 R3 byte store BE merge", {32'd0, mem[6]}, 64'h0000_0000_AB22_3344);
    chk("R5 transfer count", xn, 2);
    chk("R5 first is read", {63'd0, xw[0]}, 64'd0);
    chk("R5 second is write", {63'd0, xw[1]}, 64'd1);
    chk("R9 no ld_valid on store", {63'd0, got_ldv}, 64'd0);

    // R5 byte store little-endian with wait states, lane 2
    ws = 2'd2;
    acc(1'b1, 3'd0, 1'b0, 1'b0, 32'h1A, 16'h0, 64'hFFFF_FFFF_FFFF_FFCD);
    chk("R5 R3 byte store LE merge", {32'd0, mem[6]}, 64'h0000_0000_ABCD_3344);
    chk("R2 store read addr aligned", {32'd0, xa[0]}, 64'h18);

    // R4 halfword stores
    ws = 2'd0;
    preload(4'd7, 32'h55667788);
    preload(4'd8, 32'h55667788);
    acc(1'b1, 3'd1, 1'b0, 1'b1, 32'h1C, 16'h0, 64'h0000_0000_0000_BEEF);
    chk("R4 half store BE off0", {32'd0, mem[7]}, 64'h0000_0000_BEEF_7788);
    acc(1'b1, 3'd1, 1'b0, 1'b0, 32'h22, 16'h0, 64'h0000_0000_0000_1234);
    chk("R4 half store LE off2", {32'd0, mem[8]}, 64'h0000_0000_1234_7788);

    // R5 word store: single write
    acc(1'b1, 3'd2, 1'b0, 1'b0, 32'h24, 16'h0, 64'h0000_0000_CAFE_F00D);
    chk("R5 word store data", {32'd0, mem[9]}, 64'h0000_0000_CAFE_F00D);
    chk("R5 word store one transfer", xn, 1);
    chk("R5 word store no read", {63'd0, xw[0]}, 64'd1);

    // R6 doubleword store then load with wait states
    acc(1'b1, 3'd3, 1'b0, 1'b0, 32'h28, 16'h0, 64'h0102_0304_0506_0708);
    chk("R6 dword store high word", {32'd0, mem[10]}, 64'h0000_0000_0102_0304);
    chk("R6 dword store low word", {32'd0, mem[11]}, 64'h0000_0000_0506_0708);
    chk("R6 dword store first addr", {32'd0, xa[0]}, 64'h28);
    chk("R6 dword store second addr", {32'd0, xa[1]}, 64'h2C);
    ws = 2'd2;
    acc(1'b0, 3'd3, 1'b0, 1'b1, 32'h28, 16'h0, 64'd0);
    chk("R6 dword load data", got_data, 64'h0102_0304_0506_0708);
    chk("R6 dword load transfers", xn, 2);
    chk("R6 dword load second addr", {32'd0, xa[1]}, 64'h2C);

    // R10 invalid size
    ws = 2'd0;
    acc(1'b1, 3'd5, 1'b0, 1'b0, 32'h30, 16'h0, 64'hDEAD);
    chk("R10 err strobe", {63'd0, got_err}, 64'd1);
    chk("R10 no transfer", xn, 0);
    @(negedge clk);
    chk("R10 err one cycle", {63'd0, err}, 64'd0);
    chk("R10 busy stays low", {63'd0, busy}, 64'd0);

    // R11 request while busy ignored
    preload(4'd12, 32'h77777777);
    ws = 2'd2;
    @(negedge clk);
    log_clr = 1'b1; req_valid = 1'b1; req_store = 1'b0; req_size = 3'd2;
    req_base = 32'h10; req_offset = '0;
    @(negedge clk);
    log_clr = 1'b0;
    req_store = 1'b1; req_base = 32'h30; req_wdata = 64'h1111_1111;
    chk("R8 busy during access", {63'd0, busy}, 64'd1);
    while (busy) @(negedge clk);
    req_valid = 1'b0;
    chk("R11 load result kept", ld_data, 64'h0000_0000_F1E2_D3C4);
    repeat (4) @(negedge clk);
    chk("R11 ignored store left memory", {32'd0, mem[12]}, 64'h0000_0000_7777_7777);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule